// File: doc/BRIEF.md
# FFT stage write-address sequencer

This block steers where a radix-2 FFT butterfly deposits its results. The butterfly produces two complex outputs per cycle, and they are stored in two memory banks, A and B. Each bank keeps the real and imaginary parts of a sample at the same address. The sequencer walks through every stage of the transform and through both halves of each stage. For every butterfly result it issues a write enable, one address per bank, and a swap flag. When the swap flag is high, the A result is routed to bank B and the B result to bank A.

A start pulse launches a full transform. All stages except the last write in strided order. In that order the two banks take interleaved even and odd slots, and at mid-stage the start offsets and the bank roles are exchanged. The final stage writes either linearly or in bit-reversed order, so that the transform's output lands in natural sample order. The choice is made by an input that is sampled together with start. A done flag reports completion.

Top module: `fft_wr_addr_seq`

## Requirements
- R1: A synchronous active-high reset clears wr_en_o, swap_o, done_o and both addresses to zero and returns the block to idle.
- R2: While idle, no write is issued until start_i is sampled high. The first write enable appears two clock edges after the edge that accepts start. Every half-stage then shows one cycle without a write, followed by N/4 consecutive write cycles.
- R3: In stages 1 to STAGES-1, during the first half of the stage, bank A addresses run 0, 2, 4, … and bank B addresses run 1, 3, 5, …, stepping by 2 on every write.
- R4: In the second half of those stages, bank A addresses run 1, 3, 5, … and bank B addresses run 0, 2, 4, …. swap_o is high on each of these writes.
- R5: swap_o is low on every write of a first half, on every write of the last stage, and whenever wr_en_o is low.
- R6: When final_linear_i was low at start, the last stage writes both banks with the same address. That address is the bit reversal of the write count k = 0 … N/2-1 over N_LOG2-1 bits. The count continues across the mid-stage boundary without restarting.
- R7: When final_linear_i was high at start, the last stage writes both banks with the address k = 0 … N/2-1 in plain order. The count continues across the mid-stage boundary.
- R8: done_o is cleared on the edge that accepts start. It goes high in the same cycle as the final write enable and stays high until the next start is accepted.
- R9: start_i and final_linear_i have no effect while a transform is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Starts a transform when the block is idle |
| final_linear_i | input | 1 | Sampled with start: 1 selects linear order for the last stage, 0 selects bit-reversed order |
| wr_en_o | output | 1 | Write strobe for both banks |
| addr_a_o | output | N_LOG2-1 | Write address for bank A |
| addr_b_o | output | N_LOG2-1 | Write address for bank B |
| swap_o | output | 1 | Route the A result to bank B and the B result to bank A |
| done_o | output | 1 | Transform complete |

## Verification
The hardest point to reach from the ports is the mid-stage boundary of the last stage. There the offsets must keep counting rather than reload, and only the second half of the bit-reversed sequence exposes a wrong reload. The stimulus runs complete transforms in both final modes and compares every cycle against a reference stream built from the write count. A start pulse with a flipped final-mode input is injected during a run, and the remaining stream must stay unchanged. A reset applied mid-transform confirms that the block drops back to a quiet idle.

// File: rtl/fft_wseq_pkg.sv
package fft_wseq_pkg;

  // Address ordering used by a stage
  typedef enum logic [1:0] {
    WMODE_STRIDED = 2'd0,
    WMODE_LINEAR  = 2'd1,
    WMODE_BITREV  = 2'd2
  } wmode_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

endpackage

// File: rtl/wseq_ctrl.sv
module wseq_ctrl
  import fft_wseq_pkg::*;
#(
  parameter int N_LOG2 = 4,
  parameter int STAGES = 4
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start_i,
  input  logic   final_linear_i,
  output logic   load_o,
  output logic   adv_o,
  output logic   half_o,
  output wmode_e mode_o,
  output logic   done_o
);

  localparam int BF_HALF = 1 << (N_LOG2 - 2);
  localparam int CW      = $clog2(BF_HALF + 1);
  localparam int SW      = (STAGES > 1) ? $clog2(STAGES) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(BF_HALF);
  localparam logic [SW-1:0] S_LAST = SW'(STAGES - 1);

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] stg_q;
  logic          half_q;
  logic          lin_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      stg_q   <= '0;
      half_q  <= 1'b0;
      lin_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (start_i) begin
            state_q <= SEQ_RUN;
            cnt_q   <= '0;
            stg_q   <= '0;
            half_q  <= 1'b0;
            lin_q   <= final_linear_i;
            done_q  <= 1'b0;
          end
        end
        default: begin
          if (cnt_q == C_LAST) begin
            cnt_q <= '0;
            if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              half_q <= 1'b0;
              if (stg_q == S_LAST) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
              end else begin
                stg_q <= stg_q + 1'b1;
              end
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    if (stg_q != S_LAST) mode_o = WMODE_STRIDED;
    else if (lin_q)      mode_o = WMODE_LINEAR;
    else                 mode_o = WMODE_BITREV;
  end

  assign load_o = (state_q == SEQ_RUN) && (cnt_q == '0);
  assign adv_o  = (state_q == SEQ_RUN) && (cnt_q != '0);
  assign half_o = half_q;
  assign done_o = done_q;

endmodule

// File: rtl/wseq_bank.sv
module wseq_bank
  import fft_wseq_pkg::*;
#(
  parameter int AW   = 3,
  parameter bit IS_B = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          adv_i,
  input  logic          half_i,
  input  wmode_e        mode_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] off_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] step;
  logic [AW-1:0] start_val;
  logic [AW-1:0] next_off;
  logic [AW-1:0] rev_off;
  logic          reload;

  always_comb begin
    if (mode_i == WMODE_STRIDED) begin
      step      = AW'(2);
      start_val = AW'(IS_B ? !half_i : half_i);
    end else begin
      step      = AW'(1);
      start_val = '0;
    end
    // Offsets reload at every half in strided mode, only at stage start otherwise
    reload   = load_i && ((mode_i == WMODE_STRIDED) || !half_i);
    next_off = off_q + step;
    for (int i = 0; i < AW; i++) begin
      rev_off[i] = next_off[AW-1-i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      addr_q <= '0;
    end else if (reload) begin
      // Pre-decrement so the first advance lands on the start value
      off_q <= start_val - step;
    end else if (adv_i) begin
      off_q  <= next_off;
      addr_q <= (mode_i == WMODE_BITREV) ? rev_off : next_off;
    end
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/fft_wr_addr_seq.sv
module fft_wr_addr_seq
  import fft_wseq_pkg::*;
#(
  parameter int N_LOG2 = 4,
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              final_linear_i,
  output logic              wr_en_o,
  output logic [N_LOG2-2:0] addr_a_o,
  output logic [N_LOG2-2:0] addr_b_o,
  output logic              swap_o,
  output logic              done_o
);

  localparam int AW = N_LOG2 - 1;

  logic   load;
  logic   adv;
  logic   half;
  wmode_e stage_mode;
  logic   wr_en_q;
  logic   swap_q;
  logic [AW-1:0] bank_addr [2];

  wseq_ctrl #(
    .N_LOG2(N_LOG2),
    .STAGES(STAGES)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .final_linear_i(final_linear_i),
    .load_o        (load),
    .adv_o         (adv),
    .half_o        (half),
    .mode_o        (stage_mode),
    .done_o        (done_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bank
    wseq_bank #(
      .AW  (AW),
      .IS_B(g == 1)
    ) u_bank (
      .clk   (clk),
      .rst   (rst),
      .load_i(load),
      .adv_i (adv),
      .half_i(half),
      .mode_i(stage_mode),
      .addr_o(bank_addr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en_q <= 1'b0;
      swap_q  <= 1'b0;
    end else begin
      wr_en_q <= adv;
      swap_q  <= adv && half && (stage_mode == WMODE_STRIDED);
    end
  end

  assign wr_en_o  = wr_en_q;
  assign swap_o   = swap_q;
  assign addr_a_o = bank_addr[0];
  assign addr_b_o = bank_addr[1];

endmodule

// File: rtl/fft_wr_addr_seq_chk.sv
module fft_wr_addr_seq_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          swap,
  input logic          done,
  input logic [AW-1:0] addr_a,
  input logic [AW-1:0] addr_b
);

  localparam logic [AW-1:0] TWO = AW'(2);

  // R5
  swap_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    swap |-> wr_en);

  // R4
  swapped_parity_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && swap) |-> (addr_a[0] && !addr_b[0]));

  // R4
  swapped_stride_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && swap && $past(wr_en) && $past(swap))
      |-> ((AW'(addr_a - $past(addr_a)) == TWO) && (AW'(addr_b - $past(addr_b)) == TWO)));

  // R8
  done_with_last_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> wr_en);

  // R8
  no_done_during_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_en) |-> !done);

endmodule

bind fft_wr_addr_seq fft_wr_addr_seq_chk #(.AW(N_LOG2 - 1)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wr_en (wr_en_o),
  .swap  (swap_o),
  .done  (done_o),
  .addr_a(addr_a_o),
  .addr_b(addr_b_o)
);

// File: tb/fft_wr_addr_seq_tb_top.sv
`timescale 1ns/1ps
module fft_wr_addr_seq_tb_top;

  localparam int N_LOG2  = 4;
  localparam int STAGES  = 4;
  localparam int AW      = N_LOG2 - 1;
  localparam int BF_HALF = 1 << (N_LOG2 - 2);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          final_linear_i = 1'b0;
  logic          wr_en_o;
  logic [AW-1:0] addr_a_o;
  logic [AW-1:0] addr_b_o;
  logic          swap_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;

  int    q_we[$];
  int    q_a[$];
  int    q_b[$];
  int    q_sw[$];
  int    q_dn[$];
  string q_tag[$];

  always #2.5 clk = ~clk;

  fft_wr_addr_seq #(.N_LOG2(N_LOG2), .STAGES(STAGES)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .final_linear_i(final_linear_i),
    .wr_en_o(wr_en_o), .addr_a_o(addr_a_o), .addr_b_o(addr_b_o),
    .swap_o(swap_o), .done_o(done_o)
  );

  function automatic int rev_bits(int v);
    int r = 0;
    for (int b = 0; b < AW; b++) if ((v >> b) & 1) r |= 1 << (AW - 1 - b);
    return r;
  endfunction

  function automatic void push(int we, int a, int b, int sw, int dn, string tag);
    q_we.push_back(we); q_a.push_back(a); q_b.push_back(b);
    q_sw.push_back(sw); q_dn.push_back(dn); q_tag.push_back(tag);
  endfunction

  // Expected per-cycle stream starting two edges after start acceptance
  function automatic void build_ref(bit lin);
    q_we.delete(); q_a.delete(); q_b.delete(); q_sw.delete(); q_dn.delete(); q_tag.delete();
    for (int st = 0; st < STAGES; st++) begin
      for (int h = 0; h < 2; h++) begin
        push(0, 0, 0, 0, 0, "R2");
        for (int i = 0; i < BF_HALF; i++) begin
          bit last = (st == STAGES - 1) && (h == 1) && (i == BF_HALF - 1);
          int k = h * BF_HALF + i;
          if (st < STAGES - 1)
            push(1, 2 * i + h, 2 * i + (1 - h), h, 0, h ? "R4" : "R3");
          else if (lin)
            push(1, k, k, 0, last, "R7");
          else
            push(1, rev_bits(k), rev_bits(k), 0, last, "R6");
        end
      end
    end
  endfunction

  task automatic check1(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_entry(int idx);
    int ok;
    checks++;
    ok = (wr_en_o == q_we[idx]) && (swap_o == q_sw[idx]) && (done_o == q_dn[idx]);
    if (q_we[idx] == 1) ok = ok && (addr_a_o == q_a[idx]) && (addr_b_o == q_b[idx]);
    if (!ok) begin
      errors++;
      $display("FAIL %s step %0d actual we=%0d a=%0d b=%0d sw=%0d done=%0d expected we=%0d a=%0d b=%0d sw=%0d done=%0d",
               q_tag[idx], idx, wr_en_o, addr_a_o, addr_b_o, swap_o, done_o,
               q_we[idx], q_a[idx], q_b[idx], q_sw[idx], q_dn[idx]);
    end
  endtask

  // inject_at < 0: no disturbance; otherwise R9 start pulse at that step
  task automatic run_transform(bit lin, int inject_at);
    build_ref(lin);
    @(negedge clk);
    start_i = 1'b1;
    final_linear_i = lin;
    @(negedge clk);                       // after accepting edge
    start_i = 1'b0;
    final_linear_i = ~lin;
    check1("R8", done_o, 0, "done cleared on start");
    for (int i = 0; i < q_we.size(); i++) begin
      @(negedge clk);
      check_entry(i);
      start_i = (i == inject_at);          // R9: ignored while running
    end
    start_i = 1'b0;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check1("R8", done_o, 1, "done held");
      check1("R2", wr_en_o, 0, "no write after completion");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check1("R1", wr_en_o, 0, "wr_en in reset");
    check1("R1", swap_o, 0, "swap in reset");
    check1("R1", done_o, 0, "done in reset");
    check1("R1", addr_a_o, 0, "addr_a in reset");
    check1("R1", addr_b_o, 0, "addr_b in reset");
    rst = 1'b0;
    // R2 stays idle without start
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check1("R2", wr_en_o, 0, "idle without start");
    end
    run_transform(1'b0, -1);   // R3 R4 R5 R6
    run_transform(1'b1, -1);   // R7
    run_transform(1'b0, 12);   // R9 with start and flipped final mode mid-run
    run_transform(1'b1, 30);   // R9 during last stage
    // R1 reset in the middle of a transform
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check1("R1", wr_en_o, 0, "wr_en after mid-run reset");
    check1("R1", swap_o, 0, "swap after mid-run reset");
    check1("R1", done_o, 0, "done after mid-run reset");
    check1("R1", addr_a_o, 0, "addr_a after mid-run reset");
    rst = 1'b0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check1("R2", wr_en_o, 0, "idle after reset");
    end
    run_transform(1'b0, -1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule